// File: doc/BRIEF.md
# Masked Interrupt Controller Register Block

This block collects interrupt requests from up to 32 peripheral lines, keeps each request in a sticky pending bit, and combines the pending bits with a software-programmed enable mask. The result is one interrupt request to the processor core. The core reaches the block through a single-cycle special-purpose register port. The port carries a 16-bit register index, a write strobe, write data, and a read-data path. The core also supplies its own read value, which the block passes through when it does not own the index.

The register index is built as (group << 11) + number. The block sits in group 9 and owns two numbers there: number 0 is the enable mask and number 2 is the pending status. A write to the mask takes effect on the request output one cycle later, without waiting for a new interrupt event. Software acknowledges pending bits by writing ones to the status register. A parameter picks, line by line, whether a line is level-sensitive or sets its bit only on a rising edge.

Top module: `pic_regs`

## Requirements
- R1: The mask register answers at index 0x4800 (group 9, number 0) and the status register answers at index 0x4802 (group 9, number 2). A read of either index returns that register's current value in the same cycle, with unused upper bits read as zero.
- R2: After reset the status register reads zero, the mask reads the MASK_RESET parameter value (zero by default), and irq_req is low.
- R3: A write to index 0x4800 replaces the whole mask with the write data from the next clock edge on.
- R4: A write to index 0x4802 clears every status bit whose write-data bit is 1 and leaves every bit written as 0 unchanged.
- R5: A level-sensitive line that is high at a clock edge sets its status bit at that edge. The bit then stays set after the line falls, until software clears it.
- R6: When a line's set condition and a software clear of the same bit fall on one edge, the bit ends up set.
- R7: irq_req is high exactly when the bitwise AND of status and mask is non-zero. After a mask write it reflects the new mask in the following cycle.
- R8: A read of any index other than 0x4800 and 0x4802, including the other numbers of group 9, returns spr_rdata_in unchanged.
- R9: A write to any index other than 0x4800 and 0x4802 changes neither the mask nor the status register.
- R10: A line selected as edge-sensitive by the EDGE_LINES parameter (lines 8 to 15 by default) sets its status bit only at an edge where it is high and was low at the previous edge. A line held high does not set the bit again after a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| spr_addr | input | 16 | Register index from the core |
| spr_we | input | 1 | Write strobe for the indexed register |
| spr_wdata | input | 32 | Write data |
| spr_rdata_in | input | 32 | Read value the core supplies, passed through for indices not owned |
| spr_rdata | output | 32 | Read data back to the core |
| irq_lines | input | 32 | Peripheral interrupt request lines |
| irq_req | output | 1 | Combined interrupt request to the core |

## Verification
The hardest case to reach from the ports is a software clear that lands on the same edge as a new set of the same bit. For a level line this needs the line high on the clearing edge. For an edge line it needs a rising transition at that exact edge. The directed part of the bench lines up the line transition with the clearing write in one step, for one level line and one edge line. It also holds an edge line high across a clear to show that no new set follows. The random phase draws indices between the two owned slots, their group neighbours and arbitrary values. It uses sparse line patterns so that pending bits, clears and mask changes overlap often.

// File: rtl/pic_pkg.sv
package pic_pkg;

    localparam int IDX_W        = 16;
    localparam int GROUP_SHIFT  = 11;

    typedef enum logic [1:0] {
        SLOT_NONE = 2'd0,
        SLOT_MASK = 2'd1,
        SLOT_STAT = 2'd2
    } slot_e;

    // Builds a register index from its group and number.
    function automatic logic [IDX_W-1:0] reg_index(input int unsigned group,
                                                   input int unsigned number);
        return IDX_W'((group << GROUP_SHIFT) + number);
    endfunction

    typedef struct packed {
        logic [IDX_W-1:0] addr;
        logic             we;
        logic [31:0]      wdata;
    } spr_req_t;

endpackage

// File: rtl/pic_decode.sv
module pic_decode
    import pic_pkg::*;
#(
    parameter int unsigned GROUP    = 9,
    parameter int unsigned MASK_NUM = 0,
    parameter int unsigned STAT_NUM = 2
) (
    input  logic [IDX_W-1:0] addr,
    output slot_e            slot
);
    localparam logic [IDX_W-1:0] MASK_IDX = reg_index(GROUP, MASK_NUM);
    localparam logic [IDX_W-1:0] STAT_IDX = reg_index(GROUP, STAT_NUM);

    always_comb begin
        if (addr == MASK_IDX)      slot = SLOT_MASK;
        else if (addr == STAT_IDX) slot = SLOT_STAT;
        else                       slot = SLOT_NONE;
    end
endmodule

// File: rtl/pic_capture.sv
module pic_capture #(
    parameter int unsigned          NUM_LINES  = 32,
    parameter logic [NUM_LINES-1:0] EDGE_LINES = '0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] lines,
    input  logic [NUM_LINES-1:0] clr,
    output logic [NUM_LINES-1:0] status
);
    logic [NUM_LINES-1:0] set_v;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        if (EDGE_LINES[i]) begin : g_edge
            logic prev_q;
            always_ff @(posedge clk) begin
                if (rst) prev_q <= 1'b0;
                else     prev_q <= lines[i];
            end
            assign set_v[i] = lines[i] & ~prev_q;
        end else begin : g_level
            assign set_v[i] = lines[i];
        end

        // Set has priority over a software clear on the same edge.
        always_ff @(posedge clk) begin
            if (rst)           status[i] <= 1'b0;
            else if (set_v[i]) status[i] <= 1'b1;
            else if (clr[i])   status[i] <= 1'b0;
        end
    end

    // R4
    clear_takes_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status & $past(clr & ~set_v)) == '0));
    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status & $past(set_v)) == $past(set_v)));
    // R5
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((~status & $past(status) & ~$past(clr)) == '0));
endmodule

// File: rtl/pic_regs.sv
module pic_regs
    import pic_pkg::*;
#(
    parameter int unsigned          NUM_LINES  = 32,
    parameter int unsigned          DATA_W     = 32,
    parameter int unsigned          GROUP      = 9,
    parameter logic [NUM_LINES-1:0] MASK_RESET = '0,
    parameter logic [NUM_LINES-1:0] EDGE_LINES = NUM_LINES'(32'h0000_FF00)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [IDX_W-1:0]     spr_addr,
    input  logic                 spr_we,
    input  logic [DATA_W-1:0]    spr_wdata,
    input  logic [DATA_W-1:0]    spr_rdata_in,
    output logic [DATA_W-1:0]    spr_rdata,
    input  logic [NUM_LINES-1:0] irq_lines,
    output logic                 irq_req
);
    slot_e                slot;
    logic [NUM_LINES-1:0] mask_q;
    logic [NUM_LINES-1:0] status;
    logic [NUM_LINES-1:0] clr_v;
    logic                 wr_mask;
    logic                 wr_stat;

    pic_decode #(
        .GROUP    (GROUP),
        .MASK_NUM (0),
        .STAT_NUM (2)
    ) u_dec (
        .addr (spr_addr),
        .slot (slot)
    );

    assign wr_mask = spr_we && (slot == SLOT_MASK);
    assign wr_stat = spr_we && (slot == SLOT_STAT);
    assign clr_v   = wr_stat ? spr_wdata[NUM_LINES-1:0] : '0;

    pic_capture #(
        .NUM_LINES  (NUM_LINES),
        .EDGE_LINES (EDGE_LINES)
    ) u_cap (
        .clk    (clk),
        .rst    (rst),
        .lines  (irq_lines),
        .clr    (clr_v),
        .status (status)
    );

    always_ff @(posedge clk) begin
        if (rst)          mask_q <= MASK_RESET;
        else if (wr_mask) mask_q <= spr_wdata[NUM_LINES-1:0];
    end

    always_comb begin
        unique case (slot)
            SLOT_MASK: spr_rdata = DATA_W'(mask_q);
            SLOT_STAT: spr_rdata = DATA_W'(status);
            default:   spr_rdata = spr_rdata_in;
        endcase
    end

    assign irq_req = |(status & mask_q);

    // R7
    mask_zero_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_mask && (spr_wdata[NUM_LINES-1:0] == '0)) |=> !irq_req);
    // R9
    stray_write_chk: assert property (@(posedge clk) disable iff (rst)
        (spr_we && (slot == SLOT_NONE)) |=> $stable(mask_q));
    // R8
    passthru_chk: assert property (@(posedge clk) disable iff (rst)
        (slot == SLOT_NONE) |-> (spr_rdata == spr_rdata_in));
endmodule

// File: tb/sim_pic_regs.sv
module sim_pic_regs;
    localparam logic [15:0] A_MASK = 16'h4800;
    localparam logic [15:0] A_STAT = 16'h4802;
    localparam logic [31:0] EDGE   = 32'h0000_FF00;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] spr_addr;
    logic        spr_we;
    logic [31:0] spr_wdata;
    logic [31:0] spr_rdata_in;
    logic [31:0] spr_rdata;
    logic [31:0] irq_lines;
    logic        irq_req;

    int n_chk  = 0;
    int n_fail = 0;
    logic [31:0] m_mask, m_stat, m_prev;

    always #10 clk = ~clk;

    pic_regs u0 (
        .clk          (clk),
        .rst          (rst),
        .spr_addr     (spr_addr),
        .spr_we       (spr_we),
        .spr_wdata    (spr_wdata),
        .spr_rdata_in (spr_rdata_in),
        .spr_rdata    (spr_rdata),
        .irq_lines    (irq_lines),
        .irq_req      (irq_req)
    );

    function automatic logic [31:0] exp_rd(input logic [15:0] a, input logic [31:0] pass);
        if (a == A_MASK) return m_mask;
        if (a == A_STAT) return m_stat;
        return pass;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One bus cycle: drive, check combinational outputs, then advance model at the edge.
    task automatic step(input logic [15:0] a, input logic we, input logic [31:0] wd,
                        input logic [31:0] ln, input logic [31:0] pass);
        logic [31:0] setv, clr;
        @(negedge clk);
        spr_addr = a; spr_we = we; spr_wdata = wd; irq_lines = ln; spr_rdata_in = pass;
        #1;
        if (a == A_MASK)      check("R3 mask read", spr_rdata, exp_rd(a, pass));
        else if (a == A_STAT) check("R1 status read", spr_rdata, exp_rd(a, pass));
        else                  check("R8 pass-through", spr_rdata, exp_rd(a, pass));
        check("R7 irq", {31'b0, irq_req}, {31'b0, |(m_stat & m_mask)});
        @(posedge clk);
        setv   = (ln & ~EDGE) | (ln & ~m_prev & EDGE);
        clr    = (we && a == A_STAT) ? wd : 32'h0;
        m_stat = (m_stat & ~clr) | setv;
        if (we && a == A_MASK) m_mask = wd;
        m_prev = ln;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [15:0] a;
        logic [31:0] ln;
        void'($urandom(32'd1234));
        rst = 1'b1; spr_addr = '0; spr_we = 1'b0; spr_wdata = '0;
        spr_rdata_in = '0; irq_lines = '0;
        m_mask = '0; m_stat = '0; m_prev = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R2: reset state
        spr_addr = A_STAT; #1; check("R2 status after reset", spr_rdata, 32'h0);
        spr_addr = A_MASK; #1; check("R2 mask after reset", spr_rdata, 32'h0);
        check("R2 irq after reset", {31'b0, irq_req}, 32'h0);

        // R5: level line 3 sets and stays set after it drops
        step(A_STAT, 0, 0, 32'h8, 32'h0);
        step(A_STAT, 0, 0, 32'h0, 32'h0);
        check("R5 sticky level bit", spr_rdata, 32'h8);
        // R7: mask write shows on the next cycle
        step(A_MASK, 1, 32'h8, 32'h0, 32'h0);
        step(A_MASK, 0, 0, 32'h0, 32'h0);
        check("R7 irq after mask write", {31'b0, irq_req}, 32'h1);
        // R4: clear with a mixed pattern; bit 3 cleared only
        step(A_STAT, 0, 0, 32'h11, 32'h0);
        step(A_STAT, 1, 32'h0000_0008, 32'h0, 32'h0);
        step(A_STAT, 0, 0, 32'h0, 32'h0);
        check("R4 write-one clear", spr_rdata, 32'h11);
        // R6: level line 0 high on the clearing edge
        step(A_STAT, 1, 32'h1, 32'h1, 32'h0);
        step(A_STAT, 0, 0, 32'h0, 32'h0);
        check("R6 set beats clear (level)", spr_rdata & 32'h1, 32'h1);
        // R6 + R10: edge line 9 rises on the clearing edge
        step(A_STAT, 1, 32'h200, 32'h200, 32'h0);
        step(A_STAT, 0, 0, 32'h200, 32'h0);
        check("R6 set beats clear (edge)", spr_rdata & 32'h200, 32'h200);
        // R10: held-high edge line does not re-set after clear
        step(A_STAT, 1, 32'h200, 32'h200, 32'h0);
        step(A_STAT, 0, 0, 32'h200, 32'h0);
        check("R10 held edge line stays clear", spr_rdata & 32'h200, 32'h0);
        // R9: writes to group neighbours touch nothing
        step(16'h4801, 1, 32'hFFFF_FFFF, 32'h0, 32'hA5A5_0001);
        step(16'h4803, 1, 32'hFFFF_FFFF, 32'h0, 32'hA5A5_0002);
        step(A_MASK, 0, 0, 32'h0, 32'h0);
        check("R9 mask unchanged", spr_rdata, 32'h8);
        step(A_STAT, 0, 0, 32'h0, 32'h0);
        check("R9 status unchanged", spr_rdata, m_stat);
        // R3: full-word mask write
        step(A_MASK, 1, 32'hDEAD_BEEF, 32'h0, 32'h0);
        step(A_MASK, 0, 0, 32'h0, 32'h0);
        check("R3 full mask word", spr_rdata, 32'hDEAD_BEEF);

        // Random phase
        for (int k = 0; k < 400; k++) begin
            case ($urandom % 6)
                0, 1: a = A_MASK;
                2, 3: a = A_STAT;
                4:    a = 16'h4800 + 16'($urandom % 8);
                default: a = 16'($urandom);
            endcase
            ln = (($urandom % 3) == 0) ? (32'd1 << ($urandom % 32)) : 32'h0;
            if (($urandom % 5) == 0) ln = ln | m_prev;
            step(a, ($urandom % 3) == 0, $urandom, ln, $urandom);
        end
        finish_run();
    end
endmodule